// File: doc/BRIEF.md
# DRAM Refresh and Power-Mode Tracker

This block sits beside a synchronous DRAM command stream and follows the device's refresh and low-power behaviour cycle by cycle. It samples the clock-enable pin and the chip-select, row-strobe, column-strobe and write-enable pins at every rising edge. It also takes one precharged-status bit per bank. From these it keeps the mode the device must be in, the row and bank that the next refresh will hit, and a set of single-cycle violation flags. A controller model or a protocol monitor can use these outputs to catch illegal refresh and power-down sequences. All timing limits are counts of clock cycles.

The state machine has four states. IDLE is the normal access state. AREF is the auto-refresh busy window. SREF is self refresh. PDN is power down. The transitions are as follows:
- IDLE to AREF: an accepted auto-refresh command.
- IDLE to SREF: an accepted self-refresh command.
- IDLE to PDN: clock enable sampled low without a self-refresh command.
- AREF to IDLE: taken automatically when the row-cycle window closes, with no precharge needed.
- SREF to IDLE and PDN to IDLE: clock enable sampled high.

In SREF an internal timer refreshes on its own. Two gap timers run in every state. One covers the row-cycle time after refresh activity. The other covers the precharge time after a precharge command.

Top module: `dram_pwr_tracker`

## Requirements
- R1: After reset, mode is IDLE (code 0), the refresh address is zero and all four violation flags are low.
- R2: An auto refresh is chip-select, row strobe and column strobe low with write enable and clock enable high. In IDLE, with every bank precharged and no row-cycle gap open, it is accepted. Mode shows AREF (code 1) from the next cycle, and the tracker returns to IDLE T_RC-1 edges after the command edge.
- R3: The refresh address is the concatenation {row, bank}, with the bank in the low bits. It advances by one on every accepted refresh and on every internal self-refresh tick, and wraps to zero after its all-ones value.
- R4: A refresh command of either kind, issued in IDLE or AREF while any bank-precharged bit is low, raises err_bank_open for one cycle. The command is ignored: no mode change and no address advance.
- R5: During the T_RC-1 edges after an accepted auto refresh, a refresh command raises err_trc for one cycle and is ignored. An activate (row strobe low, column strobe and write enable high) or a read/write (row strobe high, column strobe low) with clock enable high does the same. The same command T_RC edges later is legal.
- R6: A self refresh is chip-select, row strobe, column strobe and clock enable low with write enable high. In IDLE, under the same conditions as R2, it moves mode to SREF (code 2) and advances the refresh address once.
- R7: While in SREF with clock enable low, every other pin is ignored. The address advances once every T_SREF cycles, the first advance coming T_SREF edges after entry.
- R8: Clock enable sampled high in SREF returns mode to IDLE on the next cycle. It also opens a T_RC row-cycle gap that is checked as in R5.
- R9: In IDLE, clock enable sampled low without a self-refresh command moves mode to PDN (code 3) on the next cycle. Clock enable sampled high in PDN returns mode to IDLE on the next cycle.
- R10: A power-down entry raises err_pd_entry for one cycle if any bank is not precharged, or if it falls within T_RP-1 edges of a precharge command (chip-select, row strobe and write enable low, column strobe high). The entry still takes place.
- R11: If clock enable is still low T_REF_LIMIT edges after power-down entry, err_pd_overstay pulses for one cycle, once per stay. A stay that ends at exactly T_REF_LIMIT edges raises no flag.
- R12: With chip-select high, the strobe pins carry no command: nothing changes and no flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable pin as sampled |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_idle | input | NUM_BANKS | One bit per bank, high when that bank is precharged |
| mode | output | 2 | 0 IDLE, 1 AREF, 2 SREF, 3 PDN |
| rfsh_row | output | ROW_BITS | Row field of the next refresh address |
| rfsh_bank | output | log2(NUM_BANKS) | Bank field of the next refresh address |
| err_bank_open | output | 1 | Refresh attempted with a bank open |
| err_trc | output | 1 | Command inside the row-cycle gap |
| err_pd_entry | output | 1 | Power-down entry without precharge or tRP |
| err_pd_overstay | output | 1 | Power-down stay exceeded the refresh limit |

## Verification
The bench hits the row-cycle gap on both sides of its boundary: one edge before it closes and exactly when it closes. It does this after an auto refresh and again after a self-refresh exit. A timer that is off by one would either flag a legal command or let an early one through. Power-down stays of exactly the limit and beyond it separate a correct overstay flag from one that fires early, fires late or repeats. Self refresh is held long enough for three internal ticks while the pins carry activate patterns and banks are shown open, so a tracker that leaks pin decoding into SREF would raise false flags. Thirty-two auto refreshes wrap the address counter, which shows the bank field changing fastest and the counter rolling over to zero.

// File: rtl/dram_trk_pkg.sv
package dram_trk_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_AREF = 2'd1,
        MODE_SREF = 2'd2,
        MODE_PDN  = 2'd3
    } trk_mode_e;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RW,
        CMD_PRE,
        CMD_AREF,
        CMD_SREF,
        CMD_OTHER
    } dram_cmd_e;

endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
    import dram_trk_pkg::*;
(
    input  logic      cke,
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output dram_cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:         cmd = CMD_NOP;
                3'b011:         cmd = CMD_ACT;
                3'b101, 3'b100: cmd = CMD_RW;
                3'b010:         cmd = CMD_PRE;
                3'b001:         cmd = cke ? CMD_AREF : CMD_SREF;
                default:        cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
    parameter int GAP = 6,
    parameter int W   = $clog2(GAP + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    output logic [W-1:0] count
);

    // Loaded with GAP-1 so a command exactly GAP edges later sees zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= W'(GAP - 1);
        end else if (count != '0) begin
            count <= count - W'(1);
        end
    end

endmodule

// File: rtl/dram_rfsh_ctr.sv
module dram_rfsh_ctr #(
    parameter int ROW_BITS  = 12,
    parameter int BANK_BITS = 2,
    localparam int ADDR_W   = ROW_BITS + BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    output logic [ROW_BITS-1:0]  row,
    output logic [BANK_BITS-1:0] bank
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (adv) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign row  = addr_q[ADDR_W-1:BANK_BITS];
    assign bank = addr_q[BANK_BITS-1:0];

endmodule

// File: rtl/dram_pwr_tracker.sv
module dram_pwr_tracker
    import dram_trk_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int ROW_BITS    = 12,
    parameter int T_RC        = 6,
    parameter int T_RP        = 3,
    parameter int T_SREF      = 16,
    parameter int T_REF_LIMIT = 64,
    localparam int BANK_BITS  = $clog2(NUM_BANKS),
    localparam int ADDR_W     = ROW_BITS + BANK_BITS,
    localparam int TRC_W      = $clog2(T_RC + 1),
    localparam int TRP_W      = $clog2(T_RP + 1),
    localparam int STMR_W     = $clog2(T_SREF),
    localparam int PDC_W      = $clog2(T_REF_LIMIT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [NUM_BANKS-1:0] bank_idle,
    output logic [1:0]           mode,
    output logic [ROW_BITS-1:0]  rfsh_row,
    output logic [BANK_BITS-1:0] rfsh_bank,
    output logic                 err_bank_open,
    output logic                 err_trc,
    output logic                 err_pd_entry,
    output logic                 err_pd_overstay
);

    trk_mode_e         state_q, state_d;
    dram_cmd_e         cmd;
    logic [TRC_W-1:0]  trc_cnt;
    logic [TRP_W-1:0]  trp_cnt;
    logic [STMR_W-1:0] stmr_q;
    logic [PDC_W-1:0]  pdc_q;
    logic [ADDR_W-1:0] addr_vec;

    logic all_pre, is_ref, is_access, live, trc_busy, trp_busy;
    logic ref_ok, aref_go, sref_go, pd_go, sref_tick;
    logic trc_load, trp_load, adv;
    logic viol_bank, viol_trc, viol_pd, viol_stay;

    // ---------------------------------------------------------------
    // Command decode and gap timers
    // ---------------------------------------------------------------
    dram_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    dram_gap_timer #(.GAP(T_RC), .W(TRC_W)) u_trc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (trc_load),
        .count (trc_cnt)
    );

    dram_gap_timer #(.GAP(T_RP), .W(TRP_W)) u_trp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (trp_load),
        .count (trp_cnt)
    );

    dram_rfsh_ctr #(.ROW_BITS(ROW_BITS), .BANK_BITS(BANK_BITS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .row   (rfsh_row),
        .bank  (rfsh_bank)
    );

    assign addr_vec = {rfsh_row, rfsh_bank};

    // ---------------------------------------------------------------
    // Event qualification
    // ---------------------------------------------------------------
    assign all_pre   = &bank_idle;
    assign is_ref    = (cmd == CMD_AREF) || (cmd == CMD_SREF);
    assign is_access = (cmd == CMD_ACT) || (cmd == CMD_RW);
    assign live      = (state_q == MODE_IDLE) || (state_q == MODE_AREF);
    assign trc_busy  = (trc_cnt != '0);
    assign trp_busy  = (trp_cnt != '0);

    assign ref_ok    = (state_q == MODE_IDLE) && is_ref && all_pre && !trc_busy;
    assign aref_go   = ref_ok && (cmd == CMD_AREF);
    assign sref_go   = ref_ok && (cmd == CMD_SREF);
    assign pd_go     = (state_q == MODE_IDLE) && !cke && (cmd != CMD_SREF);
    assign sref_tick = (state_q == MODE_SREF) && !cke &&
                       (stmr_q == STMR_W'(T_SREF - 1));

    assign trc_load  = aref_go || ((state_q == MODE_SREF) && cke);
    assign trp_load  = live && (cmd == CMD_PRE);
    assign adv       = aref_go || sref_go || sref_tick;

    assign viol_bank = live && is_ref && !all_pre;
    assign viol_trc  = live && trc_busy && (is_ref || (cke && is_access));
    assign viol_pd   = pd_go && (!all_pre || trp_busy);
    assign viol_stay = (state_q == MODE_PDN) && !cke &&
                       (pdc_q == PDC_W'(T_REF_LIMIT - 1));

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_IDLE: begin
                if (aref_go)      state_d = MODE_AREF;
                else if (sref_go) state_d = MODE_SREF;
                else if (pd_go)   state_d = MODE_PDN;
            end
            MODE_AREF: begin
                if (trc_cnt == TRC_W'(1)) state_d = MODE_IDLE;
            end
            MODE_SREF: begin
                if (cke) state_d = MODE_IDLE;
            end
            MODE_PDN: begin
                if (cke) state_d = MODE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_IDLE;
        else        state_q <= state_d;
    end

    // ---------------------------------------------------------------
    // Self-refresh interval timer and power-down stay counter
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stmr_q <= '0;
        end else if (sref_go) begin
            stmr_q <= '0;
        end else if ((state_q == MODE_SREF) && !cke) begin
            stmr_q <= sref_tick ? '0 : stmr_q + STMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdc_q <= '0;
        end else if (pd_go) begin
            pdc_q <= '0;
        end else if ((state_q == MODE_PDN) && !cke &&
                     (pdc_q != PDC_W'(T_REF_LIMIT))) begin
            pdc_q <= pdc_q + PDC_W'(1);
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    assign mode = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_bank_open   <= 1'b0;
            err_trc         <= 1'b0;
            err_pd_entry    <= 1'b0;
            err_pd_overstay <= 1'b0;
        end else begin
            err_bank_open   <= viol_bank;
            err_trc         <= viol_trc;
            err_pd_entry    <= viol_pd;
            err_pd_overstay <= viol_stay;
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    AST_AREF_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_IDLE) && (cmd == CMD_AREF) && all_pre && !trc_busy)
        |=> (addr_vec == $past(addr_vec) + ADDR_W'(1))); // R2

    AST_OPEN_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live && is_ref && !all_pre) |=> (addr_vec == $past(addr_vec))); // R4

    AST_AREF_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_AREF) |-> (trc_cnt != '0)); // R5

    AST_SREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_SREF) && !cke) |=> (state_q == MODE_SREF)); // R7

    AST_PD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_PDN) && cke) |=> (state_q == MODE_IDLE)); // R9

    AST_STAY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pd_overstay |=> !err_pd_overstay); // R11

endmodule

// File: tb/dram_pwr_tracker_test.sv
module dram_pwr_tracker_test;

    localparam int NB    = 4;
    localparam int RB    = 3;
    localparam int TRC   = 5;
    localparam int TRP   = 3;
    localparam int TSR   = 6;
    localparam int LIM   = 10;
    localparam int AMOD  = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, cke, cs_n, ras_n, cas_n, we_n;
    logic [NB-1:0] bank_idle;
    logic [1:0]    mode;
    logic [RB-1:0] rfsh_row;
    logic [1:0]    rfsh_bank;
    logic          err_bank_open, err_trc, err_pd_entry, err_pd_overstay;

    dram_pwr_tracker #(
        .NUM_BANKS(NB), .ROW_BITS(RB), .T_RC(TRC), .T_RP(TRP),
        .T_SREF(TSR), .T_REF_LIMIT(LIM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bank_idle(bank_idle), .mode(mode),
        .rfsh_row(rfsh_row), .rfsh_bank(rfsh_bank),
        .err_bank_open(err_bank_open), .err_trc(err_trc),
        .err_pd_entry(err_pd_entry), .err_pd_overstay(err_pd_overstay)
    );

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    logic [10:0] q_exp[$];
    string       q_req[$];
    logic [10:0] mon_exp;
    string       mon_req;

    // Reference model state, built from the requirements
    int ms = 0, maddr = 0, mtrc = 0, mtrp = 0, mstmr = 0, mpdc = 0;

    function automatic logic [10:0] observed();
        return {mode, rfsh_row, rfsh_bank,
                err_bank_open, err_trc, err_pd_entry, err_pd_overstay};
    endfunction

    // Monitor: compares each cycle's outputs with the queued expectation
    always @(posedge clk) begin
        #2;
        if (q_exp.size() != 0) begin
            mon_exp = q_exp.pop_front();
            mon_req = q_req.pop_front();
            tests_run++;
            if (observed() !== mon_exp) begin
                tests_failed++;
                $display("FAIL %s: actual %b expected %b (mode,addr,flags)",
                         mon_req, observed(), mon_exp);
            end
        end
    end

    // Driver: applies one cycle of pins and pushes the expected outputs
    task automatic step(input logic k, input logic c, input logic r,
                        input logic a, input logic w,
                        input logic [NB-1:0] bk, input string req);
        bit ref_a, ref_s, act, rw, pre, allp, live, busy;
        bit ok, pdgo, tick, eb, et, ep, eo;
        int ns;
        @(negedge clk);
        cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; bank_idle = bk;
        ref_a = !c && !r && !a && w && k;
        ref_s = !c && !r && !a && w && !k;
        act   = !c && !r && a && w;
        rw    = !c && r && !a;
        pre   = !c && !r && a && !w;
        allp  = &bk;
        live  = (ms == 0) || (ms == 1);
        busy  = (mtrc != 0);
        eb    = live && (ref_a || ref_s) && !allp;
        et    = live && busy && (ref_a || ref_s || (k && (act || rw)));
        ok    = (ms == 0) && (ref_a || ref_s) && allp && !busy;
        pdgo  = (ms == 0) && !k && !ref_s;
        ep    = pdgo && (!allp || mtrp != 0);
        eo    = (ms == 3) && !k && (mpdc == LIM - 1);
        tick  = (ms == 2) && !k && (mstmr == TSR - 1);
        ns = ms;
        case (ms)
            0: if (ok && ref_a) ns = 1; else if (ok && ref_s) ns = 2;
               else if (pdgo) ns = 3;
            1: if (mtrc == 1) ns = 0;
            default: if (k) ns = 0;
        endcase
        if (ok || tick) maddr = (maddr + 1) % AMOD;
        if ((ms == 2) && !k) mstmr = tick ? 0 : mstmr + 1;
        if (ok && ref_s) mstmr = 0;
        if (pdgo) mpdc = 0;
        else if ((ms == 3) && !k && mpdc < LIM) mpdc = mpdc + 1;
        if ((ok && ref_a) || ((ms == 2) && k)) mtrc = TRC - 1;
        else if (mtrc > 0) mtrc = mtrc - 1;
        if (live && pre) mtrp = TRP - 1;
        else if (mtrp > 0) mtrp = mtrp - 1;
        ms = ns;
        q_exp.push_back({2'(ns), 5'(maddr), eb, et, ep, eo});
        q_req.push_back(req);
    endtask

    task automatic nop(input int n, input string req);
        repeat (n) step(1, 1, 1, 1, 1, 4'hF, req);
    endtask

    task automatic pd_hold(input int n, input string req);
        repeat (n) step(0, 1, 1, 1, 1, 4'hF, req);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    endtask

    initial begin
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1;
        cas_n = 1'b1; we_n = 1'b1; bank_idle = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tests_run++;
        if (observed() !== 11'd0) begin
            tests_failed++;
            $display("FAIL R1: actual %b expected %b", observed(), 11'd0);
        end

        // R12: deselected, strobes carry a refresh pattern
        nop(2, "R12");
        step(1, 1, 0, 0, 1, 4'hF, "R12");
        step(1, 1, 0, 1, 1, 4'hF, "R12");

        // R2: auto refresh accepted, AREF window then idle
        step(1, 0, 0, 0, 1, 4'hF, "R2");
        nop(6, "R2");

        // R5: commands inside the gap, then exactly at its end
        step(1, 0, 0, 0, 1, 4'hF, "R5");
        nop(1, "R5");
        step(1, 0, 0, 1, 1, 4'hF, "R5");   // activate at +2
        step(1, 0, 0, 0, 1, 4'hF, "R5");   // refresh at +3, ignored
        step(1, 0, 1, 0, 1, 4'hF, "R5");   // read at +4
        step(1, 0, 0, 1, 1, 4'hF, "R5");   // activate at +5, legal
        nop(5, "R5");

        // R4: refreshes with a bank open
        step(1, 0, 0, 0, 1, 4'b1011, "R4");
        step(0, 0, 0, 0, 1, 4'b0111, "R4");
        nop(2, "R4");

        // R3: wrap of the {row,bank} counter
        for (int i = 0; i < AMOD; i++) begin
            step(1, 0, 0, 0, 1, 4'hF, "R3");
            nop(TRC - 1, "R3");
        end

        // R9: power-down entry and exit
        pd_hold(4, "R9");
        nop(2, "R9");

        // R10: entry too soon after precharge, legal entry, bank open
        step(1, 0, 0, 1, 0, 4'hF, "R10");
        pd_hold(1, "R10");
        nop(1, "R10");
        step(1, 0, 0, 1, 0, 4'hF, "R10");
        nop(2, "R10");
        pd_hold(1, "R10");
        nop(1, "R10");
        step(0, 1, 1, 1, 1, 4'b1110, "R10");
        nop(1, "R10");

        // R11: stay of exactly the limit, then beyond it
        pd_hold(LIM, "R11");
        nop(2, "R11");
        pd_hold(LIM + 3, "R11");
        nop(2, "R11");

        // R6 and R7: self refresh with junk on the pins
        step(0, 0, 0, 0, 1, 4'hF, "R6");
        repeat (20) step(0, 0, 0, 1, 1, 4'b0000, "R7");

        // R8: exit, then commands in the new gap
        nop(1, "R8");
        step(1, 0, 0, 1, 1, 4'hF, "R8");
        step(0, 0, 0, 0, 1, 4'hF, "R8");
        nop(4, "R8");
        step(1, 0, 0, 0, 1, 4'hF, "R8");
        nop(6, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual hung run expected completion");
            summary();
            $finish;
        end
    end

endmodule